// File: doc/BRIEF.md
# Single-Slot Registered Handoff Queue

This block holds at most one message between a producer and a consumer. Both sides use a valid/ready handshake, and a transfer happens on a side in any cycle where valid and ready are both high. The message width is a parameter and defaults to 16 bits.

Every output comes straight from a register. A message cannot pass from input to output in the cycle it arrives. The producer-side ready is not derived from the consumer-side ready. This cuts every combinational path through the block, so it can be placed between two timing-critical regions. The cost is throughput. A slot that is occupied cannot also take a new message in the cycle it is emptied, so a continuous stream moves at one message every two cycles.

The control is a two-state machine:
- `HQ_VACANT`: the slot is empty and the producer side is ready.
- `HQ_LOADED`: the slot holds a message and the consumer side sees valid.

The transitions are:
- **accept**: `HQ_VACANT` to `HQ_LOADED`, when `in_valid` is high.
- **idle**: `HQ_VACANT` to `HQ_VACANT`, when `in_valid` is low.
- **release**: `HQ_LOADED` to `HQ_VACANT`, when `out_ready` is high.
- **stall**: `HQ_LOADED` to `HQ_LOADED`, when `out_ready` is low.

The data register loads only on an accept.

Top module: `onedeep_hold_queue`

## Requirements
- R1: After reset is asserted (rst_n low) and released, `in_ready` is 1 and `out_valid` is 0.
- R2: A message accepted in one cycle appears on `out_data` with `out_valid` high in the next cycle. In the accept cycle itself `out_valid` is 0.
- R3: While the slot is full, `in_ready` is 0, even in a cycle where `out_ready` is 1.
- R4: While the slot is full and `out_ready` is low, `out_valid` stays 1 and `out_data` stays unchanged.
- R5: After a release, the slot is empty in the next cycle (`in_ready` 1, `out_valid` 0) and can accept a new message in that cycle.
- R6: An `in_valid` with new data presented while the slot is full has no effect. The stored message is the one later delivered.
- R7: While the slot is empty, `out_ready` has no effect, and with `in_valid` low the slot stays empty.
- R8: With `in_valid` and `out_ready` both held high, the block alternates between accept and release cycles and delivers messages in arrival order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Producer offers a message |
| in_ready | output | 1 | Slot is empty and will take a message |
| in_data | input | WIDTH | Producer message |
| out_valid | output | 1 | Slot holds a message |
| out_ready | input | 1 | Consumer takes the message |
| out_data | output | WIDTH | Stored message |

## Verification
The only internal state is one bit of occupancy and the stored word, and both ports mirror the occupancy bit directly. A wrong state bit therefore shows on `in_ready` and `out_valid` in the very next cycle. A wrong load enable shows as a wrong or changed `out_data` no later than the cycle after the offending handshake. The bench compares both ready/valid pairs and the data against a behavioural queue on every clock. A state fault cannot hide for more than one cycle.

// File: rtl/hq_pkg.sv
package hq_pkg;
    typedef enum logic {
        HQ_VACANT = 1'b0,
        HQ_LOADED = 1'b1
    } hq_state_e;

    localparam int unsigned HQ_DEFAULT_WIDTH = 16;
endpackage

// File: rtl/hq_ctrl.sv
module hq_ctrl
    import hq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic out_ready,
    output logic in_ready,
    output logic out_valid,
    output logic load_en
);
    hq_state_e state_q;
    hq_state_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HQ_VACANT;
        else        state_q <= state_d;
    end

    // transitions: accept, idle, release, stall
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HQ_VACANT: if (in_valid)  state_d = HQ_LOADED;  // accept
            HQ_LOADED: if (out_ready) state_d = HQ_VACANT;  // release
            default:                  state_d = HQ_VACANT;
        endcase
    end

    // outputs depend on the state only, plus the load strobe
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        load_en   = 1'b0;
        unique case (state_q)
            HQ_VACANT: begin
                in_ready = 1'b1;
                load_en  = in_valid;
            end
            HQ_LOADED: out_valid = 1'b1;
            default: ;
        endcase
    end

    AST_ACCEPT_SHOWS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid); // R2
    AST_FULL_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |-> !in_ready); // R3
    AST_RELEASE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> (in_ready && !out_valid)); // R5
    AST_EMPTY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> (in_ready && !out_valid)); // R7
endmodule

// File: rtl/hq_store.sv
module hq_store #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] word_q;

    always_ff @(posedge clk) begin
        if (!rst_n)       word_q <= '0;
        else if (load_en) word_q <= d_in;
    end

    assign d_out = word_q;
endmodule

// File: rtl/onedeep_hold_queue.sv
module onedeep_hold_queue #(
    parameter int unsigned WIDTH = hq_pkg::HQ_DEFAULT_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [WIDTH-1:0] in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [WIDTH-1:0] out_data
);
    logic load_en;

    hq_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .load_en   (load_en)
    );

    hq_store #(.WIDTH(WIDTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (load_en),
        .d_in    (in_data),
        .d_out   (out_data)
    );

    AST_DATA_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_data == $past(in_data))); // R2
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R4
    AST_FULL_IGNORES_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && in_valid) |=> $stable(out_data)); // R6
endmodule

// File: tb/onedeep_hold_queue_tb.sv
`timescale 1ns/1ps
module onedeep_hold_queue_tb;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         out_ready = 1'b0;
    logic [W-1:0] in_data = '0;
    logic         in_ready;
    logic         out_valid;
    logic [W-1:0] out_data;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    string tag = "R1";

    logic [W-1:0] mdl[$];
    logic         m_enq, m_deq;

    always #2.5 clk = ~clk;

    onedeep_hold_queue #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    // behavioural reference: a queue limited to one entry, refilled only when empty
    always @(posedge clk) begin
        if (!rst_n) begin
            mdl.delete();
        end else begin
            m_deq = (mdl.size() == 1) && out_ready;
            m_enq = (mdl.size() == 0) && in_valid;
            if (m_deq) void'(mdl.pop_front());
            if (m_enq) mdl.push_back(in_data);
        end
    end

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare();
        check(tag, W'(in_ready), W'(mdl.size() == 0));
        check(tag, W'(out_valid), W'(mdl.size() == 1));
        if (mdl.size() == 1) check(tag, out_data, mdl[0]);
    endtask

    task automatic step(input logic v, input logic [W-1:0] d, input logic r);
        @(negedge clk);
        if (rst_n) compare();
        in_valid  = v;
        in_data   = d;
        out_ready = r;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        @(negedge clk);
        check("R1", W'(in_ready), W'(1));
        check("R1", W'(out_valid), W'(0));

        // R7: consumer ready while empty, no input
        tag = "R7";
        step(0, 16'h1111, 1); step(0, 16'h2222, 1); step(0, 0, 0);
        check("R7", W'(in_ready), W'(1));

        // R2: accept, valid not before next cycle
        tag = "R2";
        step(1, 16'hA5C3, 0);
        @(negedge clk);
        check("R2", W'(out_valid), W'(1));
        check("R2", out_data, 16'hA5C3);

        // R4 and R6: stall with new offers while full
        tag = "R6";
        step(1, 16'hDEAD, 0); step(1, 16'hBEEF, 0);
        tag = "R4";
        step(0, 16'h0000, 0); step(0, 16'h0000, 0);
        check("R6", out_data, 16'hA5C3);
        check("R4", W'(out_valid), W'(1));

        // R3: consumer ready while full, producer must see not ready
        tag = "R3";
        step(1, 16'h7777, 1);
        check("R3", W'(in_ready), W'(0));
        // R5: empty next cycle, accepts then
        tag = "R5";
        step(1, 16'h7777, 0);
        step(0, 16'h0, 0);
        check("R5", out_data, 16'h7777);

        // R8: streaming with both sides always willing
        tag = "R8";
        for (int i = 0; i < 40; i++) step(1, W'(16'h100 + i), 1);
        for (int i = 0; i < 30; i++) step(i[0], W'($urandom), i[1] | i[2]);
        tag = "R5";
        step(0, 0, 1); step(0, 0, 1); step(0, 0, 0);
        check("R5", W'(in_ready), W'(1));

        // R1: reset again while full
        step(1, 16'h4242, 0); step(0, 0, 0);
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", W'(in_ready), W'(1));
        check("R1", W'(out_valid), W'(0));

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule